// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block sits beside the Execute stage of a five-stage in-order integer pipeline whose stages run Fetch, Execute, Memory, Align, Writeback. For every source operand of the instruction in Execute it decides where the value comes from. The options are the register-file read, the result of the instruction now in Memory, or the result of the instruction now in Align. It keeps its own copy of the destination tags (write flag, destination index, load marker) of the instructions in Memory and Align. It advances these tags every clock.

Load data is aligned one stage later than ALU results, so a load in Memory can never supply an operand. When an Execute-stage instruction reads a register that a load in Memory will write, the block raises a stall for one cycle and inserts a bubble into Memory. On the following cycle the load has moved to Align and its data is bypassed from there. Back-to-back dependent ALU instructions need no stall.

The surrounding pipeline holds its Fetch and Execute registers while the stall output is high. The register-file read it presents must already include every write from instructions that have left Align.

Top module: `opfwd_hazard_unit`

## Requirements
- R1: When a source index is non-zero and equals the destination of the Memory-stage instruction, and that instruction writes a register and is not a load, the operand is the Memory result port and the select code is 1.
- R2: When no Memory-stage bypass applies and the Align-stage instruction writes a non-zero register equal to the source index, the operand is the Align result port and the select code is 2.
- R3: When both the Memory and Align stages qualify for the same source, the Memory result is chosen (select code 1).
- R4: A load in the Memory stage never supplies an operand. If a valid Execute instruction reads its non-zero destination, stall_o and bubble_o are high in that cycle.
- R5: A load-use stall lasts exactly one cycle. In the next cycle the dependent operand comes from Align (select code 2) with the load data.
- R6: Source index 0 is never bypassed (select code 0) and never causes a stall.
- R7: A stage whose write flag is low is ignored for bypass and stall, even when its destination index matches.
- R8: With no qualifying match the operand is the register-file value and the select code is 0.
- R9: A dependent ALU instruction directly after another ALU instruction proceeds with no stall.
- R10: After reset the Memory and Align tags are empty, so no bypass or stall occurs until instructions have entered them. A stalled cycle enters Memory as an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_src_i | input | NUM_SRC x REG_AW | Source register indices of the Execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_dst_i | input | REG_AW | Destination index of the Execute instruction |
| ex_load_i | input | 1 | Execute instruction is a load |
| rf_data_i | input | NUM_SRC x XLEN | Register-file read values per source |
| mem_res_i | input | XLEN | Result of the Memory-stage instruction (not valid for loads) |
| aln_res_i | input | XLEN | Result of the Align-stage instruction (ALU or aligned load data) |
| op_o | output | NUM_SRC x XLEN | Selected operand values |
| fwd_sel_o | output | NUM_SRC x 2 | Per-source select: 0 register file, 1 Memory, 2 Align |
| stall_o | output | 1 | Hold Fetch and Execute this cycle |
| bubble_o | output | 1 | Insert an empty slot into Memory this cycle |

## Verification
A behavioural pipeline in the bench runs a long random program over only four registers, so matches are dense. The mix includes loads, instructions that do not write, and empty fetch slots. This sorts each operand into a Memory bypass, an Align bypass, a shadowed Align match (Memory priority), a register-file read, or an index-0 read. Operand values are compared with a sequential architectural model, so any wrong source shows up as a data mismatch. Load results are given a poison value on the Memory port, so a bypass from a load in Memory is exposed. The stall output is compared cycle by cycle with the load-use condition, and so is the cycle after each stall.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_ALN = 2'd2
  } fwd_src_e;

  typedef struct packed {
    logic       wen;
    logic       load;
    logic [4:0] dst;
  } dst_tag_t;
endpackage

// File: rtl/opfwd_tag_pipe.sv
module opfwd_tag_pipe
  import opfwd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ex_valid_i,
  input  dst_tag_t ex_tag_i,
  input  logic     bubble_i,
  output dst_tag_t mem_tag_o,
  output dst_tag_t aln_tag_o
);
  dst_tag_t mem_q, aln_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      aln_q <= '0;
    end else begin
      mem_q <= (ex_valid_i && !bubble_i) ? ex_tag_i : '0;
      aln_q <= mem_q;
    end
  end

  assign mem_tag_o = mem_q;
  assign aln_tag_o = aln_q;

  p_bubble_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_i |=> !mem_q.wen);
  p_aln_follows_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q.wen |=> aln_q.wen);
endmodule

// File: rtl/opfwd_src_mux.sv
module opfwd_src_mux
  import opfwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  dst_tag_t          mem_tag_i,
  input  dst_tag_t          aln_tag_i,
  input  logic [XLEN-1:0]   rf_i,
  input  logic [XLEN-1:0]   mem_res_i,
  input  logic [XLEN-1:0]   aln_res_i,
  output logic [XLEN-1:0]   op_o,
  output fwd_src_e          sel_o,
  output logic              load_hit_o
);
  logic src_nz, mem_match, aln_match;

  assign src_nz    = |src_i;
  assign mem_match = src_nz && mem_tag_i.wen && (mem_tag_i.dst[REG_AW-1:0] == src_i);
  assign aln_match = src_nz && aln_tag_i.wen && (aln_tag_i.dst[REG_AW-1:0] == src_i);
  assign load_hit_o = mem_match && mem_tag_i.load;

  always_comb begin
    sel_o = SRC_RF;
    // younger producer wins; a load in Memory has no data yet
    if (mem_match && !mem_tag_i.load) sel_o = SRC_MEM;
    else if (aln_match)               sel_o = SRC_ALN;
  end

  always_comb begin
    unique case (sel_o)
      SRC_MEM: op_o = mem_res_i;
      SRC_ALN: op_o = aln_res_i;
      default: op_o = rf_i;
    endcase
  end
endmodule

// File: rtl/opfwd_hazard_unit.sv
module opfwd_hazard_unit
  import opfwd_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ex_valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0]   ex_src_i,
  input  logic                             ex_wen_i,
  input  logic [REG_AW-1:0]                ex_dst_i,
  input  logic                             ex_load_i,
  input  logic [NUM_SRC-1:0][XLEN-1:0]     rf_data_i,
  input  logic [XLEN-1:0]                  mem_res_i,
  input  logic [XLEN-1:0]                  aln_res_i,
  output logic [NUM_SRC-1:0][XLEN-1:0]     op_o,
  output logic [NUM_SRC-1:0][1:0]          fwd_sel_o,
  output logic                             stall_o,
  output logic                             bubble_o
);
  localparam int TagPad = 5 - REG_AW;

  dst_tag_t ex_tag, mem_tag, aln_tag;
  logic [NUM_SRC-1:0] load_hit;
  fwd_src_e [NUM_SRC-1:0] sel;

  always_comb begin
    ex_tag      = '0;
    ex_tag.wen  = ex_wen_i && (|ex_dst_i);
    ex_tag.load = ex_load_i;
    ex_tag.dst  = {{TagPad{1'b0}}, ex_dst_i};
  end

  opfwd_tag_pipe i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_valid_i (ex_valid_i),
    .ex_tag_i   (ex_tag),
    .bubble_i   (bubble_o),
    .mem_tag_o  (mem_tag),
    .aln_tag_o  (aln_tag)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    opfwd_src_mux #(.XLEN(XLEN), .REG_AW(REG_AW)) i_mux (
      .src_i      (ex_src_i[s]),
      .mem_tag_i  (mem_tag),
      .aln_tag_i  (aln_tag),
      .rf_i       (rf_data_i[s]),
      .mem_res_i  (mem_res_i),
      .aln_res_i  (aln_res_i),
      .op_o       (op_o[s]),
      .sel_o      (sel[s]),
      .load_hit_o (load_hit[s])
    );
    assign fwd_sel_o[s] = sel[s];

    p_no_load_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_tag.load |-> (fwd_sel_o[s] != 2'd1));
    p_zero_rf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ex_src_i[s] == '0) |-> (fwd_sel_o[s] == 2'd0));
    p_stall_then_aln_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ex_valid_i && load_hit[s]) |=> (fwd_sel_o[s] == 2'd2));
  end

  assign stall_o  = ex_valid_i && (|load_hit);
  assign bubble_o = stall_o;

  p_single_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  p_no_stall_alu_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_tag.load |-> !stall_o);
endmodule

// File: tb/test_opfwd_hazard_unit.sv
module test_opfwd_hazard_unit;
  localparam int XLEN = 32, REG_AW = 5, NS = 2, N = 3000;

  logic clk = 0, rst_ni = 0;
  always #2.5 clk = ~clk;

  logic ex_valid, ex_wen, ex_load;
  logic [NS-1:0][REG_AW-1:0] ex_src;
  logic [REG_AW-1:0] ex_dst;
  logic [NS-1:0][XLEN-1:0] rf_data, op;
  logic [XLEN-1:0] mem_res, aln_res;
  logic [NS-1:0][1:0] fsel;
  logic stall, bubble;

  opfwd_hazard_unit i_opfwd_hazard_unit (
    .clk_i(clk), .rst_ni(rst_ni), .ex_valid_i(ex_valid), .ex_src_i(ex_src),
    .ex_wen_i(ex_wen), .ex_dst_i(ex_dst), .ex_load_i(ex_load),
    .rf_data_i(rf_data), .mem_res_i(mem_res), .aln_res_i(aln_res),
    .op_o(op), .fwd_sel_o(fsel), .stall_o(stall), .bubble_o(bubble));

  int checks = 0, fails = 0;
  int p_rs[N], p_rt[N], p_rd[N];
  bit p_wen[N], p_ld[N];
  logic [XLEN-1:0] exp_a[N], exp_b[N], res[N];
  logic [XLEN-1:0] rf[4], arf[4];
  int e_idx = -1, m_idx = -1, a_idx = -1, pc = 0, retired = 0;
  bit prev_stall = 0;

  function automatic logic [XLEN-1:0] calc(int k, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    if (p_ld[k]) return (a ^ 32'h1234_0000) + k;
    return a + b + k * 3;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit writes(int k, int r);
    return k >= 0 && p_wen[k] && p_rd[k] != 0 && p_rd[k] == r;
  endfunction

  task automatic drive();
    if (e_idx >= 0) begin
      ex_valid = 1; ex_src[0] = p_rs[e_idx]; ex_src[1] = p_rt[e_idx];
      ex_wen = p_wen[e_idx]; ex_dst = p_rd[e_idx]; ex_load = p_ld[e_idx];
    end else begin
      ex_valid = 0; ex_src = '0; ex_wen = 0; ex_dst = 0; ex_load = 0;
    end
    rf_data[0] = rf[ex_src[0][1:0]] & {XLEN{ex_src[0] != 0}};
    rf_data[1] = rf[ex_src[1][1:0]] & {XLEN{ex_src[1] != 0}};
    mem_res = (m_idx >= 0 && !p_ld[m_idx]) ? res[m_idx] : 32'hDEAD_BEEF;
    aln_res = (a_idx >= 0) ? res[a_idx] : 32'hBAD0_0000;
  endtask

  task automatic check_cycle();
    bit exp_stall;
    int srcs[2];
    exp_stall = 0;
    srcs[0] = (e_idx >= 0) ? p_rs[e_idx] : 0;
    srcs[1] = (e_idx >= 0) ? p_rt[e_idx] : 0;
    if (e_idx >= 0 && m_idx >= 0 && p_ld[m_idx])
      for (int s = 0; s < 2; s++) if (writes(m_idx, srcs[s])) exp_stall = 1;
    chk(stall == exp_stall, exp_stall ? "R4" : (m_idx >= 0 && !p_ld[m_idx] ? "R9" : "R6"),
        "stall", stall, exp_stall);
    chk(bubble == exp_stall, "R4", "bubble", bubble, exp_stall);
    if (prev_stall) chk(!stall, "R5", "second stall", stall, 0);
    if (e_idx >= 0 && !exp_stall) begin
      for (int s = 0; s < 2; s++) begin
        int es; string req;
        bit mh, ah;
        mh = writes(m_idx, srcs[s]) && !p_ld[m_idx];
        ah = writes(a_idx, srcs[s]);
        es = mh ? 1 : (ah ? 2 : 0);
        if (srcs[s] == 0) req = "R6";
        else if (mh && ah) req = "R3";
        else if (mh) req = "R1";
        else if (ah && prev_stall) req = "R5";
        else if (ah) req = "R2";
        else if ((m_idx >= 0 && p_rd[m_idx] == srcs[s]) || (a_idx >= 0 && p_rd[a_idx] == srcs[s])) req = "R7";
        else req = "R8";
        chk(fsel[s] == es, req, $sformatf("sel%0d", s), fsel[s], es);
        chk(op[s] == (s == 0 ? exp_a[e_idx] : exp_b[e_idx]), req, $sformatf("op%0d", s),
            op[s], s == 0 ? exp_a[e_idx] : exp_b[e_idx]);
      end
      res[e_idx] = calc(e_idx, op[0], op[1]);
    end
    // advance the behavioural pipeline
    if (a_idx >= 0) begin
      if (p_wen[a_idx] && p_rd[a_idx] != 0) rf[p_rd[a_idx]] = res[a_idx];
      retired++;
    end
    a_idx = m_idx;
    if (exp_stall) m_idx = -1;
    else begin
      m_idx = e_idx;
      if (pc < N && $urandom_range(9) != 0) begin e_idx = pc; pc++; end
      else e_idx = -1;
    end
    prev_stall = exp_stall;
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      p_rs[k] = $urandom_range(3); p_rt[k] = $urandom_range(3); p_rd[k] = $urandom_range(3);
      p_wen[k] = $urandom_range(99) < 85; p_ld[k] = $urandom_range(99) < 30;
    end
    // directed head: ALU chain, load-use, dual match, non-writing shadow
    p_rs[0]=0; p_rt[0]=0; p_rd[0]=1; p_wen[0]=1; p_ld[0]=0;
    p_rs[1]=1; p_rt[1]=1; p_rd[1]=2; p_wen[1]=1; p_ld[1]=0;
    p_rs[2]=2; p_rt[2]=1; p_rd[2]=2; p_wen[2]=1; p_ld[2]=0;
    p_rs[3]=2; p_rt[3]=0; p_rd[3]=3; p_wen[3]=1; p_ld[3]=1;
    p_rs[4]=3; p_rt[4]=3; p_rd[4]=3; p_wen[4]=0; p_ld[4]=0;
    p_rs[5]=3; p_rt[5]=2; p_rd[5]=1; p_wen[5]=1; p_ld[5]=0;
    for (int r = 0; r < 4; r++) begin arf[r] = 0; rf[r] = 0; end
    for (int k = 0; k < N; k++) begin
      exp_a[k] = arf[p_rs[k]]; exp_b[k] = arf[p_rt[k]];
      if (p_wen[k] && p_rd[k] != 0) arf[p_rd[k]] = calc(k, exp_a[k], exp_b[k]);
    end
    // reset: Execute claims a dependency, but tags must be empty
    ex_valid = 1; ex_src[0] = 1; ex_src[1] = 2; ex_wen = 1; ex_dst = 1; ex_load = 1;
    rf_data = '0; mem_res = 32'h1111_1111; aln_res = 32'h2222_2222;
    #1;
    chk(stall == 0, "R10", "stall in reset", stall, 0);
    chk(fsel[0] == 0 && fsel[1] == 0, "R10", "sel in reset", fsel, 0);
    repeat (3) @(posedge clk);
    ex_valid = 0; ex_load = 0;
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    chk(fsel[0] == 0 && fsel[1] == 0 && !stall, "R10", "after reset", {fsel, stall}, 0);
    e_idx = 0; pc = 1;
    @(posedge clk); #1 drive();
    while (retired < N) begin
      @(negedge clk);
      check_cycle();
      @(posedge clk); #1 drive();
    end
    for (int r = 1; r < 4; r++) chk(rf[r] == arf[r], "R8", $sformatf("final r%0d", r), rf[r], arf[r]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", retired, N);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule